// File: doc/BRIEF.md
# Lane-Grid Box Renderer

This block picks the colour of every pixel on a 640x480 raster that shows a runner-style play field. The screen is split into four horizontal bands, one for each lane. Each lane is a 32-bit occupancy vector, and each set bit becomes a box in one of 32 columns, each 20 pixels wide. A player box sits in the leftmost column of whichever lane the player index selects. It is white while the game runs and red once the dead flag is raised.

An external sync generator feeds the block its 11-bit horizontal and vertical pixel counters and a blank flag. Game logic supplies the lane vectors, the player lane and the dead flag. The block returns one registered 12-bit colour word per pixel clock. Each band is 120 lines tall, and its box area is the 100 lines in the middle of the band. This leaves 10 background lines above and below the box area in every band.

Top module: `lane_box_renderer`

## Requirements
- R1: While rst_n is low, rgb is 12'h000. After rst_n rises, rgb stays 12'h000 for two more clocks while the internal reset releases.
- R2: Latency is one clock. The rgb value after a rising edge is computed from the hcnt, vcnt, blank, lane, player_lane and dead values sampled at that edge.
- R3: When blank is 1, rgb is 12'h000 whatever the other inputs are.
- R4: A pixel with hcnt >= 640 or vcnt >= 480 is 12'h000.
- R5: rgb is split as {red[11:8], green[7:4], blue[3:0]}. Obstacle colour is blue, 12'h00F. A pixel is blue when lane L bit b is set and all of these hold: 20*b <= hcnt <= 20*b+19, and 120*L+10 <= vcnt <= 120*L+109. Lane L is lane0_bits..lane3_bits, top to bottom. Bit 0 is the leftmost column.
- R6: A visible pixel is black (12'h000) in these cases: its lane bit is clear, or its line is one of the first 10 or last 10 lines of a 120-line band.
- R7: When dead is 0, the player box is white, 12'hFFF. The player box covers hcnt 0..19 and the box lines of the lane selected by player_lane, where 0 is the top lane.
- R8: When dead is 1, the player box is red, 12'hF00.
- R9: The player colour wins over an obstacle in the same cell, so bit 0 of the player's lane has no effect on the player box.
- R10: In column 0 of every lane other than the player's lane, bit 0 draws an obstacle as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_px | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hcnt | input | 11 | Horizontal pixel counter |
| vcnt | input | 11 | Vertical line counter |
| blank | input | 1 | High outside the active video area |
| lane0_bits | input | 32 | Occupancy of the top lane, bit 0 leftmost |
| lane1_bits | input | 32 | Occupancy of lane 1 |
| lane2_bits | input | 32 | Occupancy of lane 2 |
| lane3_bits | input | 32 | Occupancy of the bottom lane |
| player_lane | input | 2 | Lane that holds the player |
| dead | input | 1 | Game-over flag, turns the player red |
| rgb | output | 12 | Registered colour {R,G,B} with 4 bits each |

## Verification
The properties assume that every input is a known value at each pixel clock edge, including the edge where reset is released. They also assume that the counters may take values beyond the visible 640x480 area, so the out-of-range and blank checks cover real cases. The stimulus drives every input from time zero on the falling edge, so no input is ever unknown. Random counters are drawn past both screen limits, and blank is forced on for a share of the pixels. Directed pixels hit the box edges, band gaps and screen limits exactly.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
  localparam int NUM_LANES = 4;
  localparam int NUM_CELLS = 32;
  localparam int CNT_W     = 11;
  localparam int CELL_W    = 20;
  localparam int BAND_H    = 120;
  localparam int BOX_H     = 100;
  localparam int RGB_W     = 12;

  localparam logic [RGB_W-1:0] COL_BLACK = 12'h000;
  localparam logic [RGB_W-1:0] COL_BLUE  = 12'h00F;
  localparam logic [RGB_W-1:0] COL_WHITE = 12'hFFF;
  localparam logic [RGB_W-1:0] COL_RED   = 12'hF00;

  typedef enum logic [1:0] {
    PIX_BG     = 2'd0,
    PIX_OBST   = 2'd1,
    PIX_PLAYER = 2'd2
  } pix_kind_e;
endpackage

// File: rtl/lbr_rst_sync.sv
module lbr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/lbr_col_decode.sv
module lbr_col_decode #(
  parameter int CNT_W     = 11,
  parameter int NUM_CELLS = 32,
  parameter int CELL_W    = 20
) (
  input  logic [CNT_W-1:0]     hcnt,
  output logic [NUM_CELLS-1:0] col_hit
);
  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_col
    localparam logic [CNT_W-1:0] LO = CNT_W'(c * CELL_W);
    localparam logic [CNT_W-1:0] HI = CNT_W'((c + 1) * CELL_W);
    assign col_hit[c] = (hcnt >= LO) && (hcnt < HI);
  end
endmodule

// File: rtl/lbr_row_decode.sv
module lbr_row_decode #(
  parameter int CNT_W     = 11,
  parameter int NUM_LANES = 4,
  parameter int BAND_H    = 120,
  parameter int BOX_H     = 100
) (
  input  logic [CNT_W-1:0]     vcnt,
  output logic [NUM_LANES-1:0] row_hit
);
  localparam int BOX_TOP = (BAND_H - BOX_H) / 2;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_row
    localparam logic [CNT_W-1:0] TOP = CNT_W'(l * BAND_H + BOX_TOP);
    localparam logic [CNT_W-1:0] BOT = CNT_W'(l * BAND_H + BOX_TOP + BOX_H);
    assign row_hit[l] = (vcnt >= TOP) && (vcnt < BOT);
  end
endmodule

// File: rtl/lbr_pix_mux.sv
module lbr_pix_mux
  import lbr_pkg::*;
(
  input  logic             blank,
  input  logic             player_hit,
  input  logic             obst_hit,
  input  logic             dead,
  output logic [RGB_W-1:0] rgb_d
);
  pix_kind_e kind;

  always_comb begin
    if (blank)           kind = PIX_BG;
    else if (player_hit) kind = PIX_PLAYER;
    else if (obst_hit)   kind = PIX_OBST;
    else                 kind = PIX_BG;
  end

  always_comb begin
    unique case (kind)
      PIX_PLAYER: rgb_d = dead ? COL_RED : COL_WHITE;
      PIX_OBST:   rgb_d = COL_BLUE;
      default:    rgb_d = COL_BLACK;
    endcase
  end
endmodule

// File: rtl/lane_box_renderer.sv
module lane_box_renderer
  import lbr_pkg::*;
#(
  parameter int LANE_CNT = NUM_LANES,
  parameter int CELL_CNT = NUM_CELLS,
  parameter int CW       = CNT_W
) (
  input  logic                        clk_px,
  input  logic                        rst_n,
  input  logic [CW-1:0]               hcnt,
  input  logic [CW-1:0]               vcnt,
  input  logic                        blank,
  input  logic [CELL_CNT-1:0]         lane0_bits,
  input  logic [CELL_CNT-1:0]         lane1_bits,
  input  logic [CELL_CNT-1:0]         lane2_bits,
  input  logic [CELL_CNT-1:0]         lane3_bits,
  input  logic [$clog2(LANE_CNT)-1:0] player_lane,
  input  logic                        dead,
  output logic [RGB_W-1:0]            rgb
);
  logic                               rst_sync_n;
  logic [LANE_CNT-1:0][CELL_CNT-1:0]  lanes;
  logic [CELL_CNT-1:0]                col_hit;
  logic [LANE_CNT-1:0]                row_hit;
  logic [LANE_CNT-1:0]                lane_obst;
  logic                               obst_hit;
  logic                               player_hit;
  logic [RGB_W-1:0]                   rgb_d;
  logic [RGB_W-1:0]                   rgb_q;

  assign lanes[0] = lane0_bits;
  assign lanes[1] = lane1_bits;
  assign lanes[2] = lane2_bits;
  assign lanes[3] = lane3_bits;

  lbr_rst_sync u_rst_sync (
    .clk        (clk_px),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lbr_col_decode #(.CNT_W(CW), .NUM_CELLS(CELL_CNT), .CELL_W(CELL_W)) u_col (
    .hcnt    (hcnt),
    .col_hit (col_hit)
  );

  lbr_row_decode #(.CNT_W(CW), .NUM_LANES(LANE_CNT), .BAND_H(BAND_H), .BOX_H(BOX_H)) u_row (
    .vcnt    (vcnt),
    .row_hit (row_hit)
  );

  for (genvar l = 0; l < LANE_CNT; l++) begin : g_lane
    assign lane_obst[l] = row_hit[l] && (|(lanes[l] & col_hit));
  end

  assign obst_hit   = |lane_obst;
  assign player_hit = col_hit[0] && row_hit[player_lane];

  lbr_pix_mux u_mux (
    .blank      (blank),
    .player_hit (player_hit),
    .obst_hit   (obst_hit),
    .dead       (dead),
    .rgb_d      (rgb_d)
  );

  always_ff @(posedge clk_px or negedge rst_sync_n) begin
    if (!rst_sync_n) rgb_q <= COL_BLACK;
    else             rgb_q <= rgb_d;
  end

  assign rgb = rgb_q;
endmodule

// File: rtl/lbr_checker.sv
module lbr_checker
  import lbr_pkg::*;
(
  input logic             clk_px,
  input logic             rst_n,
  input logic [10:0]      hcnt,
  input logic [10:0]      vcnt,
  input logic             blank,
  input logic             dead,
  input logic [RGB_W-1:0] rgb
);
  p_blank_black_r3: assert property (@(posedge clk_px) disable iff (!rst_n)
    $past(blank) |-> rgb == COL_BLACK);

  p_offscreen_black_r4: assert property (@(posedge clk_px) disable iff (!rst_n)
    ($past(hcnt) >= 11'd640 || $past(vcnt) >= 11'd480) |-> rgb == COL_BLACK);

  p_white_alive_r7: assert property (@(posedge clk_px) disable iff (!rst_n)
    rgb == COL_WHITE |-> (!$past(dead) && $past(hcnt) < 11'd20));

  p_red_dead_r8: assert property (@(posedge clk_px) disable iff (!rst_n)
    rgb == COL_RED |-> ($past(dead) && $past(hcnt) < 11'd20));

  p_reset_black_r1: assert property (@(posedge clk_px)
    !rst_n |-> rgb == COL_BLACK);
endmodule

bind lane_box_renderer lbr_checker u_chk (
  .clk_px (clk_px),
  .rst_n  (rst_n),
  .hcnt   (hcnt),
  .vcnt   (vcnt),
  .blank  (blank),
  .dead   (dead),
  .rgb    (rgb)
);

// File: tb/lane_box_renderer_tb.sv
module lane_box_renderer_tb;
  logic        clk_px = 1'b0;
  logic        rst_n;
  logic [10:0] hcnt, vcnt;
  logic        blank, dead;
  logic [31:0] l0, l1, l2, l3;
  logic [1:0]  player_lane;
  logic [11:0] rgb;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_px = ~clk_px;

  lane_box_renderer u_dut (
    .clk_px(clk_px), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt), .blank(blank),
    .lane0_bits(l0), .lane1_bits(l1), .lane2_bits(l2), .lane3_bits(l3),
    .player_lane(player_lane), .dead(dead), .rgb(rgb)
  );

  function automatic logic [11:0] model(int h, int v, bit bl, logic [31:0] a,
      logic [31:0] b, logic [31:0] c, logic [31:0] d, int pl, bit dd);
    int ln, off, col;
    logic [31:0] bits;
    if (bl) return 12'h000;
    if (h >= 640 || v >= 480) return 12'h000;
    ln = v / 120; off = v % 120; col = h / 20;
    if (off < 10 || off >= 110) return 12'h000;
    if (ln == pl && col == 0) return dd ? 12'hF00 : 12'hFFF;
    case (ln) 0: bits = a; 1: bits = b; 2: bits = c; default: bits = d; endcase
    return bits[col] ? 12'h00F : 12'h000;
  endfunction

  task automatic check(string req, logic [11:0] exp);
    checks++;
    if (rgb !== exp) begin
      errors++;
      $display("FAIL %s h=%0d v=%0d actual=%h expected=%h", req, hcnt, vcnt, rgb, exp);
    end
  endtask

  function automatic string tag(logic [11:0] e);
    case (e)
      12'h00F: return "R5";
      12'hFFF: return "R7";
      12'hF00: return "R8";
      default: return "R6";
    endcase
  endfunction

  // drive at falling edge, sample 1 ns after the next rising edge (R2)
  task automatic pix(int h, int v, bit bl, string req);
    logic [11:0] e;
    @(negedge clk_px);
    hcnt = 11'(h); vcnt = 11'(v); blank = bl;
    e = model(h, v, bl, l0, l1, l2, l3, player_lane, dead);
    @(posedge clk_px); #1;
    check(req.len() == 0 ? tag(e) : req, e);
  endtask

  initial begin
    rst_n = 1'b0; hcnt = 11'd25; vcnt = 11'd20; blank = 1'b0; dead = 1'b0;
    l0 = 32'hFFFF_FFFF; l1 = 32'h0; l2 = 32'h0; l3 = 32'h0; player_lane = 2'd1;
    repeat (3) @(posedge clk_px);
    #1 check("R1", 12'h000);
    @(negedge clk_px) rst_n = 1'b1;
    @(posedge clk_px); #1 check("R1", 12'h000);
    repeat (3) @(posedge clk_px);

    // directed corners
    l0 = 32'h8000_0005; l1 = 32'h0000_0001; l2 = 32'h0000_0002; l3 = 32'h0000_0001;
    player_lane = 2'd1; dead = 1'b0;
    pix(40, 10, 0, "R5");   pix(40, 9, 0, "R6");   pix(40, 109, 0, "R5");
    pix(40, 110, 0, "R6");  pix(39, 50, 0, "R6");  pix(20, 50, 0, "R6");
    pix(639, 60, 0, "R5");  pix(640, 60, 0, "R4"); pix(639, 480, 0, "R4");
    pix(40, 60, 1, "R3");   pix(5, 200, 0, "R9");  pix(19, 229, 0, "R7");
    pix(20, 200, 0, "R6");  pix(5, 60, 0, "R10");  pix(30, 300, 0, "R5");
    pix(5, 420, 0, "R10");  pix(5, 479, 0, "R6");
    dead = 1'b1;
    pix(5, 200, 0, "R8");   pix(5, 200, 1, "R3");
    player_lane = 2'd0;
    pix(0, 10, 0, "R9");    pix(0, 130, 0, "R10");
    dead = 1'b0;

    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      if (i % 40 == 0) begin
        l0 = $urandom(); l1 = $urandom() & $urandom(); l2 = $urandom() | $urandom();
        l3 = $urandom(); player_lane = 2'($urandom_range(0, 3));
        dead = ($urandom_range(0, 3) == 0);
      end
      pix($urandom_range(0, 700), $urandom_range(0, 520), $urandom_range(0, 9) == 0, "");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin #2000000; errors++; $display("FAIL watchdog actual=timeout expected=done"); end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule